// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Event Interrupts

This block sits behind an infrared pulse encoder and holds the run-length bytes it produces until software reads them. Each byte comes in on a valid/ready stream. Software drains the buffer one byte at a time through a read strobe. It watches a status word that carries three sticky event flags and the current fill count. An event can be overflow, end of packet, or data available. The data-available event fires when the fill count goes above a level that software programs, and that level is usually set to half the depth minus one. Flags are cleared by writing ones to a mask. A single interrupt line merges the enabled flags.

The buffer depth is a parameter with two intended values, 16 and 64 entries. Back-pressure is not used: `in_ready` is always high and the producer is never stalled. A byte that arrives while the buffer is full, and no byte leaves in the same cycle, is discarded and raises the overflow flag. Software recovers by draining the buffer and clearing the flag.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: After reset the fill count is 0, all three flags are 0, `irq` is 0 and `rd_data` is 0.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte. A `rd_strobe` in a clock cycle with a non-empty buffer removes that byte at the edge. The count field `status_word[15:8]` follows every accepted push and every pop one cycle later.
- R3: A push and a pop in the same cycle on a non-empty buffer leave the count unchanged. On a full buffer the push is accepted and no overflow is raised.
- R4: A push into a full buffer with no pop in that cycle is discarded. The stored bytes and their order are kept, and the overflow flag (`status_word[0]`) is 1 from the next cycle on.
- R5: With the buffer empty, `rd_data` is 0, and a `rd_strobe` leaves the count at 0 and raises no flag.
- R6: A `pkt_end` pulse sets the packet-end flag (`status_word[1]`) in the following cycle.
- R7: The data-available flag (`status_word[4]`) is set in the cycle after one in which the count is strictly greater than the level `cfg_word[15:8]`. If it is cleared while the count is still above the level, it asserts again.
- R8: A cycle with `clr_valid` high clears each flag whose mask bit is 1: bit 0 for overflow, bit 1 for packet end, bit 4 for data available. All other mask bits have no effect. When a set and a clear hit the same flag in one cycle, the set wins. A mask of 0xFF clears all three flags.
- R9: `irq` is high exactly when at least one flag is 1 and its enable is also 1. The enables are `cfg_word[0]` for overflow, `cfg_word[1]` for packet end and `cfg_word[4]` for data available.
- R10: The count field can show a completely full buffer (the value DEPTH), and it never exceeds DEPTH.
- R11: `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Encoder byte valid |
| in_ready | output | 1 | Always 1; bytes are never stalled |
| in_data | input | DW | Encoded run-length byte |
| pkt_end | input | 1 | End-of-packet pulse from the encoder |
| rd_strobe | input | 1 | Pop the oldest byte |
| rd_data | output | DW | Oldest stored byte, 0 when empty |
| cfg_word | input | 16 | Enables in bits 0, 1, 4; level in bits 15:8 |
| clr_valid | input | 1 | Apply clear mask this cycle |
| clr_mask | input | 8 | Write-one-to-clear mask, same bit positions as the flags |
| status_word | output | 16 | Flags in bits 0, 1, 4; fill count from bit 8 |
| irq | output | 1 | Merged interrupt |

## Verification
Two pairs of operations can land in the same cycle. The first is a push and a pop, which matters most at the full boundary, where it decides whether an overflow happens. The second is a flag being set and software clearing that same flag. The stimulus drives both `in_valid` and `rd_strobe` on empty, partly filled and full buffers. It also issues clears while the level is still exceeded and while `pkt_end` pulses. A behavioural queue model predicts the count, the head byte, the flags and the interrupt, and the bench compares them every cycle.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int OVF_BIT   = 0;
  localparam int PEND_BIT  = 1;
  localparam int AVAIL_BIT = 4;
  localparam int FIELD_LSB = 8;
  localparam int NUM_EVT   = 3;

  typedef enum logic [1:0] {
    EV_OVF   = 2'd0,
    EV_PEND  = 2'd1,
    EV_AVAIL = 2'd2
  } evt_e;

  function automatic int evt_bit(input int idx);
    case (idx)
      0:       return OVF_BIT;
      1:       return PEND_BIT;
      default: return AVAIL_BIT;
    endcase
  endfunction
endpackage

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok, push_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && full && !pop_ok;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ir_evt_flags.sv
module ir_evt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end
    assign gated[g] = flag_o[g] & en_i[g];
  end

  assign irq_o = |gated;
endmodule

// File: rtl/ir_level_cmp.sv
module ir_level_cmp #(
  parameter int CNT_W = 5,
  parameter int LVL_W = 8,
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
  input  logic [CNT_W-1:0] count,
  input  logic [LVL_W-1:0] level,
  output logic             above
);
  logic [CMP_W-1:0] c_ext, l_ext;
  assign c_ext = CMP_W'(count);
  assign l_ext = CMP_W'(level);
  assign above = c_ext > l_ext;
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq #(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  parameter int CFG_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              pkt_end,
  input  logic              rd_strobe,
  output logic [DW-1:0]     rd_data,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              clr_valid,
  input  logic [7:0]        clr_mask,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  import ir_rx_pkg::*;

  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int LVL_W  = CFG_W - FIELD_LSB;
  localparam logic [CNT_W-1:0] CNT_MASK = CNT_W'(2 * DEPTH - 1);

  logic [DW-1:0]    head;
  logic [CNT_W-1:0] count;
  logic             empty, full, drop, above;
  logic [NUM_EVT-1:0] ev_set, ev_clr, ev_en, flags;
  logic             unused_cfg;

  assign in_ready = 1'b1;

  ir_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .wdata(in_data), .pop(rd_strobe),
    .head(head), .count(count), .empty(empty), .full(full), .drop(drop)
  );

  ir_level_cmp #(.CNT_W(CNT_W), .LVL_W(LVL_W)) cmp_i (
    .count(count), .level(cfg_word[CFG_W-1:FIELD_LSB]), .above(above)
  );

  always_comb begin
    ev_set = '0;
    ev_set[EV_OVF]   = drop;
    ev_set[EV_PEND]  = pkt_end;
    ev_set[EV_AVAIL] = above;
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_map
    assign ev_clr[e] = clr_valid & clr_mask[evt_bit(e)];
    assign ev_en[e]  = cfg_word[evt_bit(e)];
  end

  ir_evt_flags #(.N(NUM_EVT)) flags_i (
    .clk(clk), .rst_n(rst_n),
    .set_i(ev_set), .clr_i(ev_clr), .en_i(ev_en),
    .flag_o(flags), .irq_o(irq)
  );

  assign rd_data = empty ? '0 : head;

  always_comb begin
    status_word = '0;
    for (int e = 0; e < NUM_EVT; e++) status_word[evt_bit(e)] = flags[e];
    status_word[FIELD_LSB +: CNT_W] = count & CNT_MASK;
  end

  assign unused_cfg = ^{cfg_word[7:5], cfg_word[3:2], clr_mask[7:5], clr_mask[3:2], full};
endmodule

// File: rtl/ir_rx_fifo_irq_chk.sv
module ir_rx_fifo_irq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             pkt_end,
  input logic             rd_strobe,
  input logic [DW-1:0]    rd_data,
  input logic [2:0]       en_bits,
  input logic             clr_pend,
  input logic [CNT_W-1:0] cnt,
  input logic             f_ovf,
  input logic             f_pend,
  input logic             irq
);
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rd_strobe && cnt == CNT_W'(DEPTH) |=> f_ovf && cnt == CNT_W'(DEPTH));
  // R3
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rd_strobe && cnt != '0 |=> cnt == $past(cnt));
  // R5
  empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> rd_data == '0);
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && rd_strobe && !in_valid |=> cnt == '0);
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> f_pend);
  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend && !pkt_end |=> !f_pend);
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_bits == 3'b000 |-> !irq);
  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

bind ir_rx_fifo_irq ir_rx_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pkt_end(pkt_end), .rd_strobe(rd_strobe), .rd_data(rd_data),
  .en_bits({cfg_word[4], cfg_word[1], cfg_word[0]}),
  .clr_pend(clr_valid & clr_mask[1]),
  .cnt(status_word[8 +: ($clog2(DEPTH) + 1)]),
  .f_ovf(status_word[0]), .f_pend(status_word[1]), .irq(irq)
);

// File: tb/ir_rx_fifo_irq_tb_top.sv
module ir_rx_fifo_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, pkt_end = 1'b0, rd_strobe = 1'b0, clr_valid = 1'b0;
  logic [7:0] in_data = '0, clr_mask = '0;
  logic [15:0] cfg_word = '0;
  logic in_ready, irq;
  logic [7:0] rd_data;
  logic [15:0] status_word;

  int total = 0, bad = 0;
  string cur_req = "R1";

  byte unsigned q[$];
  bit m_ovf = 0, m_pe = 0, m_av = 0;

  ir_rx_fifo_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pkt_end(pkt_end), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .cfg_word(cfg_word), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .status_word(status_word), .irq(irq)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // reference model: behavioural queue and flags
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ovf = 0; m_pe = 0; m_av = 0;
    end else begin
      bit pop, full, s_ovf, s_av;
      pop   = rd_strobe && (q.size() > 0);
      full  = (q.size() == DEPTH);
      s_ovf = in_valid && full && !pop;
      s_av  = (q.size() > int'(cfg_word[15:8]));
      if (pop) void'(q.pop_front());
      if (in_valid && !s_ovf) q.push_back(in_data);
      m_ovf = s_ovf   | (m_ovf & !(clr_valid & clr_mask[0]));
      m_pe  = pkt_end | (m_pe  & !(clr_valid & clr_mask[1]));
      m_av  = s_av    | (m_av  & !(clr_valid & clr_mask[4]));
    end
  end

  task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] es;
    logic [7:0] ed;
    logic ei;
    es = '0;
    es[0] = m_ovf; es[1] = m_pe; es[4] = m_av;
    es[15:8] = 8'(q.size());
    ed = (q.size() > 0) ? q[0] : 8'h00;
    ei = (m_ovf & cfg_word[0]) | (m_pe & cfg_word[1]) | (m_av & cfg_word[4]);
    chk(status_word === es, "status", status_word, es);
    chk(rd_data === ed, "rd_data", {8'h0, rd_data}, {8'h0, ed});
    chk(irq === ei, "irq", {15'h0, irq}, {15'h0, ei});
    chk(in_ready === 1'b1, "in_ready R11", {15'h0, in_ready}, 16'h1);
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit pe, input bit rd,
                      input bit cv, input logic [7:0] cm);
    in_valid = v; in_data = d; pkt_end = pe; rd_strobe = rd;
    clr_valid = cv; clr_mask = cm;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    cfg_word = 16'h0713;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(1);

    // R2 ordered push then pop
    cur_req = "R2";
    for (int i = 0; i < 5; i++) step(1, 8'hA1 + 8'(i), 0, 0, 0, 8'h00);
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 1, 0, 8'h00);

    // R3 simultaneous push and pop
    cur_req = "R3";
    for (int i = 0; i < 3; i++) step(1, 8'h30 + 8'(i), 0, 0, 0, 8'h00);
    for (int i = 0; i < 4; i++) step(1, 8'h40 + 8'(i), 0, 1, 0, 8'h00);
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 1, 0, 8'h00);

    // R7 level crossing and re-assert after clear
    cur_req = "R7";
    for (int i = 0; i < 10; i++) step(1, 8'h50 + 8'(i), 0, 0, 0, 8'h00);
    idle(2);
    step(0, 8'h00, 0, 0, 1, 8'h10);
    idle(2);
    cur_req = "R8";
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 1, 0, 8'h00);
    idle(1);
    step(0, 8'h00, 0, 0, 1, 8'h10);
    idle(2);

    // R10 fill to full, R4 overflow drops and keeps contents
    cur_req = "R10";
    for (int i = 0; i < 11; i++) step(1, 8'h60 + 8'(i), 0, 0, 0, 8'h00);
    idle(1);
    cur_req = "R3";
    step(1, 8'h77, 0, 1, 0, 8'h00);
    cur_req = "R4";
    for (int i = 0; i < 3; i++) step(1, 8'hE0 + 8'(i), 0, 0, 0, 8'h00);
    idle(1);
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 1, 0, 8'h00);

    // R5 reads on empty
    cur_req = "R5";
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 1, 0, 8'h00);

    // R6 packet end, R8 clears
    cur_req = "R6";
    step(0, 8'h00, 1, 0, 0, 8'h00);
    idle(1);
    cur_req = "R8";
    step(0, 8'h00, 0, 0, 1, 8'h02);
    step(0, 8'h00, 1, 0, 1, 8'h02);
    idle(1);
    step(0, 8'h00, 0, 0, 1, 8'hEC);
    idle(1);
    step(0, 8'h00, 0, 0, 1, 8'hFF);
    idle(1);

    // R9 interrupt enables
    cur_req = "R9";
    step(0, 8'h00, 1, 0, 0, 8'h00);
    cfg_word = 16'h0700;
    idle(2);
    cfg_word = 16'h0702;
    idle(1);
    cfg_word = 16'h0701;
    idle(1);
    cfg_word = 16'h0710;
    idle(1);
    step(0, 8'h00, 0, 0, 1, 8'hFF);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule